// File: doc/BRIEF.md
# Scratchpad Command Controller

This block is the function-command layer of a single-wire temperature slave. It takes over once the address-selection layer has picked this device. From the bit layer it receives whole command and data bytes, and single read-slot requests. For each read slot it returns one bit, chosen by the command that is active. It keeps a nine-byte read image of the device:

- the converted temperature (two bytes)
- the upper and lower alarm trigger bytes
- two reserved bytes that always read as all ones
- the count-remaining byte and the count-per-degree byte
- a check byte computed while the image streams out

The block also holds a small nonvolatile copy of the two trigger bytes, with a copy busy timer, and a conversion busy timer. When a conversion finishes, the block captures the sensor values presented on its inputs. Measuring the temperature and timing the bus slots are done outside this block.

Bytes enter on a valid/ready stream, and read slots arrive on a second valid/ready stream. The block holds both ready signals high at all times, so it never applies back-pressure. A transfer happens in every cycle where valid is high. The source may present a new byte or a new slot in every cycle. The reply bit `tx_bit` is meaningful only in the cycle of a slot handshake, and it must be taken in that same cycle.

A bus reset has priority over everything else in its cycle. It drops the block back to idle until the next selection. A busy timer that has already started keeps running through a bus reset.

Top module: `sp_cmd_ctrl`

## Requirements
- R1: A `bus_reset` pulse returns the block to idle. Any byte handed over in that same cycle is discarded. Until the next `selected` pulse, bytes are ignored and every read slot returns 1.
- R2: Command 8'h4E stores the next byte as the upper trigger (image byte 2) and the byte after it as the lower trigger (image byte 3). Any further bytes are ignored. A bus reset after only the first byte leaves byte 3 unchanged.
- R3: Command 8'hBE streams image bytes 0 to 7, least significant bit first, one bit per slot. The bytes are, in order:
  - byte 0: temperature, low byte
  - byte 1: temperature, high byte
  - byte 2: upper trigger
  - byte 3: lower trigger
  - bytes 4 and 5: 8'hFF
  - byte 6: count remaining
  - byte 7: count per degree
- R4: The ninth streamed byte is a CRC over bytes 0 to 7. It uses polynomial x^8+x^5+x^4+1 in reflected form (8'h8C), starts from zero, and takes the data least significant bit first.
- R5: After the ninth byte of a read, every further read slot returns 1.
- R6: Command 8'h48 captures bytes 2 and 3 for the nonvolatile store. Read slots return 0 for COPY_CYCLES slots, counted from the cycle after the command byte, and return 1 after that. The store takes the captured values when the copy ends.
- R7: Command 8'h44 starts a conversion. Read slots return 0 for CONV_CYCLES slots, counted from the cycle after the command byte, and return 1 after that. When the conversion ends, bytes 0, 1, 6 and 7 load from `sens_temp`, `sens_remain` and `sens_per_deg`.
- R8: Command 8'h48's counterpart 8'hB8 (recall) reloads bytes 2 and 3 from the nonvolatile store, and the read slots that follow return 1. After `rst_n`, bytes 2 and 3 hold the store's initial contents.
- R9: Command 8'hB4 makes every following read slot return `ext_power` (0 means parasite power, 1 means external supply).
- R10: After any other command byte, read slots return 1 and further bytes are ignored until a bus reset.
- R11: Only the end of a copy changes the nonvolatile store. Writes, aborted writes and bus resets leave it unchanged.
- R12: `rx_ready` and `slot_ready` stay high from reset on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| bus_reset | input | 1 | Pulse: line reset seen by the bit layer |
| selected | input | 1 | Pulse: the address layer selected this device |
| rx_valid | input | 1 | Byte stream valid |
| rx_ready | output | 1 | Byte stream ready (always 1) |
| rx_byte | input | 8 | Received byte |
| slot_valid | input | 1 | Read-slot request valid |
| slot_ready | output | 1 | Read-slot ready (always 1) |
| tx_bit | output | 1 | Reply bit for the slot accepted this cycle |
| ext_power | input | 1 | 1 when an external supply is present |
| sens_temp | input | 16 | Sensor temperature word, captured when a conversion ends |
| sens_remain | input | 8 | Sensor count remaining |
| sens_per_deg | input | 8 | Sensor counts per degree |

## Verification
Two events can land in the same cycle. The first is a byte handshake in the middle of a trigger write arriving together with a bus reset. The bench drives `rx_valid` and `bus_reset` on the same clock edge, reads the image back, and expects the trigger byte to be unchanged. The second is the last busy cycle of a conversion or copy meeting a read slot. The bench issues slots back to back, starting in the cycle right after the command, and requires exactly the parameterised number of 0 replies before the first 1.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h4E;
  localparam logic [7:0] OP_READ   = 8'hBE;
  localparam logic [7:0] OP_COPY   = 8'h48;
  localparam logic [7:0] OP_CONV   = 8'h44;
  localparam logic [7:0] OP_RECALL = 8'hB8;
  localparam logic [7:0] OP_POWER  = 8'hB4;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
  localparam int unsigned IMG_BYTES    = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_COPY,
    ST_CONV,
    ST_PWR,
    ST_ONES
  } sp_state_e;

  // One bit of the reflected CRC: shift right, fold in the polynomial on feedback.
  function automatic logic [7:0] crc_step(input logic [7:0] crc, input logic din);
    logic fb;
    fb = crc[0] ^ din;
    crc_step = {1'b0, crc[7:1]} ^ (fb ? CRC_POLY_REFL : 8'h00);
  endfunction

endpackage

// File: rtl/sp_busy_timer.sv
module sp_busy_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start && cnt_q == '0) begin
      cnt_q <= CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R6/R7: an accepted start makes the timer busy on the next cycle
  a_r7_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R6/R7: the final busy cycle is followed by idle
  a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7: a busy timer is never restarted
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/sp_nvstore.sv
module sp_nvstore #(
  parameter int unsigned COPY_CYCLES = 64,
  parameter logic [7:0]  INIT_HI     = 8'h4B,
  parameter logic [7:0]  INIT_LO     = 8'h46
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       copy_go,
  input  logic [7:0] wr_hi,
  input  logic [7:0] wr_lo,
  output logic       busy,
  output logic [7:0] nv_hi,
  output logic [7:0] nv_lo
);
  logic [7:0] pend_hi_q, pend_lo_q;
  logic [7:0] nv_hi_q, nv_lo_q;
  logic       done;

  sp_busy_timer #(.CYCLES(COPY_CYCLES)) u_copy_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (copy_go),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi_q <= INIT_HI;
      pend_lo_q <= INIT_LO;
      nv_hi_q   <= INIT_HI;
      nv_lo_q   <= INIT_LO;
    end else begin
      if (copy_go && !busy) begin
        pend_hi_q <= wr_hi;
        pend_lo_q <= wr_lo;
      end
      if (done) begin
        nv_hi_q <= pend_hi_q;
        nv_lo_q <= pend_lo_q;
      end
    end
  end

  assign nv_hi = nv_hi_q;
  assign nv_lo = nv_lo_q;

  // R11: the stored contents move only in the final cycle of a copy
  a_r11_nv_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(nv_hi_q) && $stable(nv_lo_q)));

  // R6: staged values are frozen while a copy is in flight
  a_r6_pending_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pend_hi_q) && $stable(pend_lo_q)));

endmodule

// File: rtl/sp_read_stream.sv
module sp_read_stream
  import sp_pkg::*;
#(
  parameter int unsigned NBYTES = IMG_BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   slot_fire,
  input  logic [NBYTES-1:0][7:0] img_i,
  output logic                   tx_bit
);
  localparam int AW = $clog2(NBYTES + 2);
  localparam logic [AW-1:0] CRC_IDX = AW'(NBYTES);
  localparam logic [AW-1:0] END_IDX = AW'(NBYTES + 1);

  logic [AW-1:0] addr_q;
  logic [2:0]    bit_q;
  logic [7:0]    crc_q;
  logic [7:0]    cur_byte;
  logic          cur_bit;

  always_comb begin
    cur_byte = 8'hFF;
    for (int k = 0; k < int'(NBYTES); k++) begin
      if (addr_q == AW'(k)) cur_byte = img_i[k];
    end
    if (addr_q == CRC_IDX) cur_byte = crc_q;
  end

  assign cur_bit = cur_byte[bit_q];
  assign tx_bit  = cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= END_IDX;
      bit_q  <= '0;
      crc_q  <= '0;
    end else if (start) begin
      addr_q <= '0;
      bit_q  <= '0;
      crc_q  <= '0;
    end else if (slot_fire && addr_q != END_IDX) begin
      if (addr_q < CRC_IDX) crc_q <= crc_step(crc_q, cur_bit);
      bit_q <= bit_q + 1'b1;
      if (bit_q == 3'd7) addr_q <= addr_q + 1'b1;
    end
  end

  // R5: once the check byte is out, slots read as ones
  a_r5_ones_after_crc: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire && addr_q == END_IDX) |-> tx_bit);

  // R3: the byte index steps by one after the eighth bit of a byte
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && slot_fire && bit_q == 3'd7 && addr_q != END_IDX) |=> (addr_q == $past(addr_q) + 1'b1));

  // R4: the running CRC holds still while the check byte is sent
  a_r4_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && addr_q >= CRC_IDX) |=> $stable(crc_q));

endmodule

// File: rtl/sp_cmd_ctrl.sv
module sp_cmd_ctrl
  import sp_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 50000,
  parameter int unsigned COPY_CYCLES = 2500,
  parameter logic [7:0]  NV_INIT_HI  = 8'h4B,
  parameter logic [7:0]  NV_INIT_LO  = 8'h46,
  parameter logic [15:0] TEMP_INIT   = 16'h00AA,
  parameter logic [7:0]  REMAIN_INIT = 8'h0C,
  parameter logic [7:0]  PERDEG_INIT = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        selected,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        slot_valid,
  output logic        slot_ready,
  output logic        tx_bit,
  input  logic        ext_power,
  input  logic [15:0] sens_temp,
  input  logic [7:0]  sens_remain,
  input  logic [7:0]  sens_per_deg
);
  sp_state_e st_q, st_d;

  logic        rx_fire, slot_fire, quiet;
  logic        cmd_take, wr_take;
  logic        recall_go, copy_go, conv_go, rd_start;
  logic        wr_idx_q;
  logic [7:0]  trig_hi_q, trig_lo_q;
  logic [15:0] temp_q;
  logic [7:0]  remain_q, perdeg_q;
  logic        nv_busy, conv_busy, conv_done;
  logic [7:0]  nv_hi, nv_lo;
  logic        rs_bit;
  logic [IMG_BYTES-1:0][7:0] img;

  assign rx_ready   = 1'b1;
  assign slot_ready = 1'b1;
  assign rx_fire    = rx_valid && rx_ready;
  assign slot_fire  = slot_valid && slot_ready;
  assign quiet      = !bus_reset && !selected;

  assign cmd_take  = (st_q == ST_CMD) && rx_fire && quiet;
  assign wr_take   = (st_q == ST_WR)  && rx_fire && quiet;
  assign recall_go = cmd_take && (rx_byte == OP_RECALL);
  assign copy_go   = cmd_take && (rx_byte == OP_COPY);
  assign conv_go   = cmd_take && (rx_byte == OP_CONV);
  assign rd_start  = cmd_take && (rx_byte == OP_READ);

  always_comb begin
    st_d = st_q;
    if (bus_reset) begin
      st_d = ST_IDLE;
    end else if (selected) begin
      st_d = ST_CMD;
    end else begin
      unique case (st_q)
        ST_CMD: begin
          if (rx_fire) begin
            unique case (rx_byte)
              OP_WRITE: st_d = ST_WR;
              OP_READ:  st_d = ST_RD;
              OP_COPY:  st_d = ST_COPY;
              OP_CONV:  st_d = ST_CONV;
              OP_POWER: st_d = ST_PWR;
              default:  st_d = ST_ONES;
            endcase
          end
        end
        ST_WR: if (rx_fire && wr_idx_q) st_d = ST_ONES;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      wr_idx_q  <= 1'b0;
      trig_hi_q <= NV_INIT_HI;
      trig_lo_q <= NV_INIT_LO;
      temp_q    <= TEMP_INIT;
      remain_q  <= REMAIN_INIT;
      perdeg_q  <= PERDEG_INIT;
    end else begin
      st_q <= st_d;
      if (cmd_take && rx_byte == OP_WRITE) wr_idx_q <= 1'b0;
      else if (wr_take)                    wr_idx_q <= 1'b1;
      if (wr_take) begin
        if (!wr_idx_q) trig_hi_q <= rx_byte;
        else           trig_lo_q <= rx_byte;
      end else if (recall_go) begin
        trig_hi_q <= nv_hi;
        trig_lo_q <= nv_lo;
      end
      if (conv_done) begin
        temp_q   <= sens_temp;
        remain_q <= sens_remain;
        perdeg_q <= sens_per_deg;
      end
    end
  end

  sp_busy_timer #(.CYCLES(CONV_CYCLES)) u_conv_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (conv_go),
    .busy  (conv_busy),
    .done  (conv_done)
  );

  sp_nvstore #(
    .COPY_CYCLES (COPY_CYCLES),
    .INIT_HI     (NV_INIT_HI),
    .INIT_LO     (NV_INIT_LO)
  ) u_nv (
    .clk     (clk),
    .rst_n   (rst_n),
    .copy_go (copy_go),
    .wr_hi   (trig_hi_q),
    .wr_lo   (trig_lo_q),
    .busy    (nv_busy),
    .nv_hi   (nv_hi),
    .nv_lo   (nv_lo)
  );

  assign img[0] = temp_q[7:0];
  assign img[1] = temp_q[15:8];
  assign img[2] = trig_hi_q;
  assign img[3] = trig_lo_q;
  assign img[4] = 8'hFF;
  assign img[5] = 8'hFF;
  assign img[6] = remain_q;
  assign img[7] = perdeg_q;

  sp_read_stream #(.NBYTES(IMG_BYTES)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_start),
    .slot_fire (slot_fire && st_q == ST_RD),
    .img_i     (img),
    .tx_bit    (rs_bit)
  );

  always_comb begin
    unique case (st_q)
      ST_RD:   tx_bit = rs_bit;
      ST_COPY: tx_bit = !nv_busy;
      ST_CONV: tx_bit = !conv_busy;
      ST_PWR:  tx_bit = ext_power;
      default: tx_bit = 1'b1;
    endcase
  end

  // R1: a bus reset always lands in idle
  a_r1_reset_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (st_q == ST_IDLE));

  // R2: trigger bytes change only on an accepted write byte or a recall
  a_r2_trig_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_take && !recall_go) |=> ($stable(trig_hi_q) && $stable(trig_lo_q)));

  // R7: sensor image bytes change only when a conversion ends
  a_r7_temp_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> ($stable(temp_q) && $stable(remain_q) && $stable(perdeg_q)));

  // R10: an unknown command never leaves the all-ones state without reset or selection
  a_r10_ones_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ONES && quiet) |=> (st_q == ST_ONES));

endmodule

// File: tb/sp_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sp_cmd_ctrl_bench;
  localparam int unsigned CONV = 20;
  localparam int unsigned COPY = 12;
  localparam logic [7:0]  NVH  = 8'h4B;
  localparam logic [7:0]  NVL  = 8'h46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset = 1'b0, selected = 1'b0;
  logic        rx_valid = 1'b0, slot_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_ready, slot_ready, tx_bit;
  logic        ext_power = 1'b1;
  logic [15:0] sens_temp = 16'h0000;
  logic [7:0]  sens_remain = 8'h00, sens_per_deg = 8'h00;

  int n_chk = 0, n_fail = 0;
  logic [7:0]  e_hi, e_lo, e_nvh, e_nvl, e_rem, e_per;
  logic [15:0] e_temp;
  logic [7:0]  rd [0:8];

  always #2 clk = ~clk;

  sp_cmd_ctrl #(
    .CONV_CYCLES(CONV), .COPY_CYCLES(COPY),
    .NV_INIT_HI(NVH), .NV_INIT_LO(NVL),
    .TEMP_INIT(16'h00AA), .REMAIN_INIT(8'h0C), .PERDEG_INIT(8'h10)
  ) u_sp_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .selected(selected),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .tx_bit(tx_bit),
    .ext_power(ext_power), .sens_temp(sens_temp), .sens_remain(sens_remain),
    .sens_per_deg(sens_per_deg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] b [0:8]);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic mix;
        mix = c[0] ^ b[i][j];
        c = c >> 1;
        if (mix) c = c ^ 8'h8C;
      end
    end
    return c;
  endfunction

  task automatic pulse_reset();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  task automatic start_txn();
    pulse_reset();
    selected = 1'b1;
    @(negedge clk); selected = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  task automatic slot(output logic b);
    @(negedge clk); slot_valid = 1'b1;
    #1 b = tx_bit;
    @(posedge clk); #1 slot_valid = 1'b0;
  endtask

  task automatic read_image(output int extra_zero);
    logic b;
    start_txn();
    send_byte(8'hBE);
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 8; j++) begin
        slot(b);
        rd[i][j] = b;
      end
    end
    extra_zero = 0;
    for (int k = 0; k < 8; k++) begin
      slot(b);
      if (!b) extra_zero++;
    end
  endtask

  task automatic check_image(input string tag);
    int ez;
    logic [7:0] ex [0:8];
    read_image(ez);
    ex[0] = e_temp[7:0]; ex[1] = e_temp[15:8]; ex[2] = e_hi; ex[3] = e_lo;
    ex[4] = 8'hFF; ex[5] = 8'hFF; ex[6] = e_rem; ex[7] = e_per; ex[8] = 8'h00;
    ex[8] = ref_crc(ex);
    chk({tag, " R3 temperature bytes"}, {rd[1], rd[0]}, {ex[1], ex[0]});
    chk({tag, " R2 trigger bytes"}, {rd[2], rd[3]}, {ex[2], ex[3]});
    chk({tag, " R3 reserved bytes"}, {rd[4], rd[5]}, 16'hFFFF);
    chk({tag, " R7 count bytes"}, {rd[6], rd[7]}, {ex[6], ex[7]});
    chk({tag, " R4 crc byte"}, rd[8], ex[8]);
    chk({tag, " R5 ones after crc"}, ez, 0);
  endtask

  task automatic write_trig(input logic [7:0] h, input logic [7:0] l);
    start_txn();
    send_byte(8'h4E); send_byte(h); send_byte(l);
    send_byte(8'h99);
    e_hi = h; e_lo = l;
  endtask

  task automatic count_busy(input logic [7:0] op, output int zeros);
    logic b;
    start_txn();
    send_byte(op);
    zeros = 0;
    for (int i = 0; i < 200; i++) begin
      slot(b);
      if (b) break;
      zeros++;
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int z;
    logic b;
    int ones;
    e_hi = NVH; e_lo = NVL; e_nvh = NVH; e_nvl = NVL;
    e_temp = 16'h00AA; e_rem = 8'h0C; e_per = 8'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", {rx_ready, slot_ready}, 2'b11);

    // R8: power-up image holds the store's initial trigger bytes
    check_image("R8 power-up");

    // R2/R3/R4: sweep of trigger writes, CRC recomputed per pattern
    for (int i = 0; i < 8; i++) begin
      logic [7:0] h;
      h = 8'(i * 37 + 5);
      write_trig(h, ~h ^ 8'(i));
      check_image("R2 sweep");
    end

    // R7: conversions over a set of signed temperature words
    for (int k = 0; k < 4; k++) begin
      logic [15:0] tv;
      tv = (k == 0) ? 16'hFF92 : (k == 1) ? 16'h0032 : (k == 2) ? 16'hFFCE : 16'h00FA;
      sens_temp = tv; sens_remain = 8'(3 * k + 1); sens_per_deg = 8'(8'h10 + k);
      count_busy(8'h44, z);
      chk("R7 conversion busy slots", z, CONV);
      e_temp = tv; e_rem = 8'(3 * k + 1); e_per = 8'(8'h10 + k);
      check_image("R7 conversion");
    end

    // R6: copy busy length, then R8/R11 recall brings back copied values
    write_trig(8'h5A, 8'hC3);
    count_busy(8'h48, z);
    chk("R6 copy busy slots", z, COPY);
    e_nvh = 8'h5A; e_nvl = 8'hC3;
    write_trig(8'h11, 8'h22);
    start_txn(); send_byte(8'hB8);
    ones = 0;
    for (int i = 0; i < 8; i++) begin slot(b); if (b) ones++; end
    chk("R8 recall slots return ones", ones, 8);
    e_hi = e_nvh; e_lo = e_nvl;
    check_image("R8 recall");

    // R2: abort after first data byte; R11 store keeps copied values
    start_txn(); send_byte(8'h4E); send_byte(8'h77);
    e_hi = 8'h77;
    check_image("R2 aborted write");
    start_txn(); send_byte(8'hB8);
    e_hi = e_nvh; e_lo = e_nvl;
    check_image("R11 store after abort");

    // R1: byte and bus reset in the same cycle -> byte discarded
    start_txn(); send_byte(8'h4E);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hE7; bus_reset = 1'b1;
    @(posedge clk); #1 rx_valid = 1'b0; bus_reset = 1'b0;
    check_image("R1 reset collides with byte");

    // R1: without selection, bytes ignored and slots read one
    pulse_reset();
    send_byte(8'hBE);
    ones = 0;
    for (int i = 0; i < 8; i++) begin slot(b); if (b) ones++; end
    chk("R1 unselected slots", ones, 8);
    send_byte(8'h4E); send_byte(8'h01); send_byte(8'h02);
    check_image("R1 unselected write ignored");

    // R1/R3: a read cut short by reset restarts from byte 0
    start_txn(); send_byte(8'hBE);
    for (int i = 0; i < 13; i++) slot(b);
    check_image("R1 restarted read");

    // R9: power mode query, both supply states
    for (int p = 0; p < 2; p++) begin
      ext_power = p[0];
      start_txn(); send_byte(8'hB4);
      ones = 0;
      for (int i = 0; i < 4; i++) begin slot(b); if (b) ones++; end
      chk("R9 power mode bits", ones, p * 4);
    end
    ext_power = 1'b1;

    // R10: unknown command, later bytes ignored
    start_txn(); send_byte(8'h12); send_byte(8'h4E); send_byte(8'h33);
    ones = 0;
    for (int i = 0; i < 16; i++) begin slot(b); if (b) ones++; end
    chk("R10 unknown command slots", ones, 16);
    check_image("R10 unknown command no write");

    finish_run();
  end
endmodule